// File: doc/BRIEF.md
# Data-Space Effective Address Generator

This block computes the data-space address used by load and store operations in a small 8-bit microcontroller core. Each accepted request carries an addressing-mode code, a pointer-pair select, the current values of the three 16-bit pointer pairs, a 6-bit displacement, a 6-bit I/O address and a 16-bit absolute address taken from the second word of a two-word instruction. The block returns the effective address. For the auto-modify modes it also returns the updated pointer value, the pair it belongs to and a write-enable, so the register file can write the pair back.

Supported modes are absolute, I/O-direct, plain pointer-indirect, pointer plus displacement, post-increment and pre-decrement. Pair X sits in registers 27:26, Y in 29:28 and Z in 31:30, high byte first. The register file concatenates each pair into one 16-bit input. Any combination outside the legal set raises an illegal flag, forces the address to zero and blocks write-back. Results are registered, one cycle after the request.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and after its release with no request, valid_o, ea_o, wb_en_o, wb_ptr_o, wb_val_o and illegal_o are all zero.
- R2: Mode code 0 (absolute) gives ea_o = abs_addr_i with no write-back; ptr_sel_i is ignored, including the unused code 3.
- R3: Mode code 1 (I/O-direct) gives ea_o = io_addr_i + 0x20, so ea_o lies in 0x20..0x5F; ptr_sel_i is ignored and there is no write-back.
- R4: Mode code 2 (indirect) gives ea_o equal to the selected pointer (ptr_sel_i code 0 = X, 1 = Y, 2 = Z) with no write-back.
- R5: Mode code 3 (displacement) with Y or Z gives ea_o = pointer + disp_i (disp_i unsigned 0..63) with no write-back; with X it is illegal.
- R6: Mode code 4 (post-increment) gives ea_o equal to the pointer before the update, wb_en_o = 1, wb_val_o = pointer + 1 and wb_ptr_o = ptr_sel_i.
- R7: Mode code 5 (pre-decrement) gives ea_o = wb_val_o = pointer - 1, wb_en_o = 1 and wb_ptr_o = ptr_sel_i.
- R8: Mode codes 6 and 7, and ptr_sel_i = 3 in any pointer mode (codes 2..5), set illegal_o = 1 and force ea_o = 0, wb_en_o = 0 and wb_val_o = 0.
- R9: Outputs for a request with valid_i high appear with valid_o high at the next rising clock edge. In a cycle with valid_o low, wb_en_o, illegal_o and wb_val_o are zero. wb_val_o and wb_ptr_o are zero whenever wb_en_o is low.
- R10: All pointer arithmetic wraps modulo 2^16. 0xFFFF + 1 gives 0x0000, 0x0000 - 1 gives 0xFFFF, and 0xFFF0 + 63 gives 0x002F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing-mode code |
| ptr_sel_i | input | 2 | Pointer pair select: 0 X, 1 Y, 2 Z |
| ptr_x_i | input | 16 | Pair X value (r27:r26) |
| ptr_y_i | input | 16 | Pair Y value (r29:r28) |
| ptr_z_i | input | 16 | Pair Z value (r31:r30) |
| disp_i | input | 6 | Unsigned displacement |
| io_addr_i | input | 6 | I/O location number |
| abs_addr_i | input | 16 | Absolute address from second instruction word |
| valid_o | output | 1 | Result valid |
| ea_o | output | 16 | Effective data-space address |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_ptr_o | output | 2 | Pair to write back |
| wb_val_o | output | 16 | New pointer value |
| illegal_o | output | 1 | Illegal mode or pointer combination |

## Verification
A wrong mode decode or a wrong pointer select appears at ea_o in the cycle after the request, because the result register is the only state in the block. An off-by-one in the auto-modify adders shows up when wb_val_o is compared with ea_o in that same cycle. A write-enable that leaks into legal non-modify modes, or stays high after an idle request, appears within one cycle at wb_en_o. Such a leak would corrupt a pointer pair in the register file.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W  = 16;
  localparam int MODE_W  = 3;
  localparam int SEL_W   = 2;

  localparam logic [MODE_W-1:0] AM_ABS     = 3'd0;
  localparam logic [MODE_W-1:0] AM_IO      = 3'd1;
  localparam logic [MODE_W-1:0] AM_IND     = 3'd2;
  localparam logic [MODE_W-1:0] AM_DISP    = 3'd3;
  localparam logic [MODE_W-1:0] AM_POSTINC = 3'd4;
  localparam logic [MODE_W-1:0] AM_PREDEC  = 3'd5;

  localparam logic [SEL_W-1:0] PS_X = 2'd0;
  localparam logic [SEL_W-1:0] PS_Y = 2'd1;
  localparam logic [SEL_W-1:0] PS_Z = 2'd2;

  typedef struct packed {
    logic [ADDR_W-1:0] ea;
    logic              wb_en;
    logic [SEL_W-1:0]  wb_ptr;
    logic [ADDR_W-1:0] wb_val;
    logic              illegal;
  } ea_res_t;
endpackage

// File: rtl/ea_ptr_sel.sv
module ea_ptr_sel #(
  parameter int ADDR_W  = 16,
  parameter int NUM_PTR = 3,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_PTR*ADDR_W-1:0] ptrs_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [ADDR_W-1:0]         ptr_o,
  output logic                      sel_ok_o
);
  logic [NUM_PTR-1:0] hit;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_hit
    assign hit[g] = (sel_i == SEL_W'(g));
  end

  always_comb begin
    ptr_o = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (hit[i]) ptr_o = ptrs_i[i*ADDR_W +: ADDR_W];
    end
  end

  assign sel_ok_o = |hit;
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DISP_W  = 6,
  parameter int IO_W    = 6,
  parameter int IO_BASE = 32
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              sel_ok_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [IO_W-1:0]   io_i,
  input  logic [ADDR_W-1:0] abs_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [ADDR_W-1:0] wb_val_o,
  output logic              wb_en_o,
  output logic              illegal_o
);
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(IO_BASE);

  logic [ADDR_W-1:0] inc, dec, disp_sum, io_ea;

  assign inc      = ptr_i + ONE;
  assign dec      = ptr_i - ONE;
  assign disp_sum = ptr_i + ADDR_W'(disp_i);
  assign io_ea    = BASE + ADDR_W'(io_i);

  always_comb begin
    ea_o      = '0;
    wb_val_o  = '0;
    wb_en_o   = 1'b0;
    illegal_o = 1'b0;
    unique case (mode_i)
      AM_ABS: ea_o = abs_i;
      AM_IO:  ea_o = io_ea;
      AM_IND: begin
        if (sel_ok_i) ea_o = ptr_i;
        else          illegal_o = 1'b1;
      end
      AM_DISP: begin
        // displacement only through Y or Z
        if (sel_ok_i && sel_i != PS_X) ea_o = disp_sum;
        else                           illegal_o = 1'b1;
      end
      AM_POSTINC: begin
        if (sel_ok_i) begin
          ea_o     = ptr_i;
          wb_val_o = inc;
          wb_en_o  = 1'b1;
        end else illegal_o = 1'b1;
      end
      AM_PREDEC: begin
        if (sel_ok_i) begin
          ea_o     = dec;
          wb_val_o = dec;
          wb_en_o  = 1'b1;
        end else illegal_o = 1'b1;
      end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DISP_W  = 6,
  parameter int IO_W    = 6,
  parameter int IO_BASE = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        ptr_sel_i,
  input  logic [15:0]       ptr_x_i,
  input  logic [15:0]       ptr_y_i,
  input  logic [15:0]       ptr_z_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [IO_W-1:0]   io_addr_i,
  input  logic [15:0]       abs_addr_i,
  output logic              valid_o,
  output logic [15:0]       ea_o,
  output logic              wb_en_o,
  output logic [1:0]        wb_ptr_o,
  output logic [15:0]       wb_val_o,
  output logic              illegal_o
);
  localparam int NUM_PTR = 3;

  logic [ADDR_W-1:0] ptr_sel;
  logic              sel_ok;
  ea_res_t           res_d, res_q;
  logic              vld_q;

  ea_ptr_sel #(
    .ADDR_W (ADDR_W),
    .NUM_PTR(NUM_PTR),
    .SEL_W  (SEL_W)
  ) i_ptr_sel (
    .ptrs_i  ({ptr_z_i, ptr_y_i, ptr_x_i}),
    .sel_i   (ptr_sel_i),
    .ptr_o   (ptr_sel),
    .sel_ok_o(sel_ok)
  );

  ea_calc #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .IO_W   (IO_W),
    .IO_BASE(IO_BASE)
  ) i_calc (
    .mode_i   (mode_i),
    .sel_i    (ptr_sel_i),
    .sel_ok_i (sel_ok),
    .ptr_i    (ptr_sel),
    .disp_i   (disp_i),
    .io_i     (io_addr_i),
    .abs_i    (abs_addr_i),
    .ea_o     (res_d.ea),
    .wb_val_o (res_d.wb_val),
    .wb_en_o  (res_d.wb_en),
    .illegal_o(res_d.illegal)
  );

  assign res_d.wb_ptr = res_d.wb_en ? ptr_sel_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (valid_i) begin
      vld_q <= 1'b1;
      res_q <= res_d;
    end else begin
      vld_q          <= 1'b0;
      res_q.wb_en    <= 1'b0;
      res_q.wb_val   <= '0;
      res_q.wb_ptr   <= '0;
      res_q.illegal  <= 1'b0;
    end
  end

  assign valid_o   = vld_q;
  assign ea_o      = res_q.ea;
  assign wb_en_o   = res_q.wb_en;
  assign wb_ptr_o  = res_q.wb_ptr;
  assign wb_val_o  = res_q.wb_val;
  assign illegal_o = res_q.illegal;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [2:0]  mode_i,
  input logic [1:0]  ptr_sel_i,
  input logic        valid_o,
  input logic [15:0] ea_o,
  input logic        wb_en_o,
  input logic [1:0]  wb_ptr_o,
  input logic [15:0] wb_val_o,
  input logic        illegal_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  p_valid_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (valid_o == $past(valid_i)));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!wb_en_o && !illegal_o && wb_val_o == 16'h0));

  p_wb_only_auto_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wb_en_o) |-> ($past(mode_i) == 3'd4 || $past(mode_i) == 3'd5));

  p_postinc_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wb_en_o && $past(mode_i) == 3'd4) |-> (wb_val_o == ea_o + 16'd1));

  p_predec_same_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wb_en_o && $past(mode_i) == 3'd5) |-> (wb_val_o == ea_o));

  p_io_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 3'd1) |-> (ea_o >= 16'h0020 && ea_o <= 16'h005F));

  p_illegal_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wb_en_o && ea_o == 16'h0 && wb_val_o == 16'h0));

  p_illegal_flex_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) >= 3'd6) |-> illegal_o);

  p_wb_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wb_en_o) |-> (wb_ptr_o == $past(ptr_sel_i)));

  p_no_stray_ptr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wb_en_o |-> (wb_ptr_o == 2'd0));
endmodule

bind ea_gen ea_gen_chk i_ea_gen_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mode_i   (mode_i),
  .ptr_sel_i(ptr_sel_i),
  .valid_o  (valid_o),
  .ea_o     (ea_o),
  .wb_en_o  (wb_en_o),
  .wb_ptr_o (wb_ptr_o),
  .wb_val_o (wb_val_o),
  .illegal_o(illegal_o)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  ptr_sel_i = '0;
  logic [15:0] ptr_x_i = '0, ptr_y_i = '0, ptr_z_i = '0;
  logic [5:0]  disp_i = '0, io_addr_i = '0;
  logic [15:0] abs_addr_i = '0;
  logic        valid_o, wb_en_o, illegal_o;
  logic [15:0] ea_o, wb_val_o;
  logic [1:0]  wb_ptr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] ea;
    logic        wb_en;
    logic [1:0]  wb_ptr;
    logic [15:0] wb_val;
    logic        illegal;
    string       req;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen i_ea_gen (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .ptr_sel_i(ptr_sel_i), .ptr_x_i(ptr_x_i), .ptr_y_i(ptr_y_i), .ptr_z_i(ptr_z_i),
    .disp_i(disp_i), .io_addr_i(io_addr_i), .abs_addr_i(abs_addr_i),
    .valid_o(valid_o), .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_ptr_o(wb_ptr_o),
    .wb_val_o(wb_val_o), .illegal_o(illegal_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [2:0] m, input logic [1:0] s,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] z,
      input logic [5:0] d, input logic [5:0] io, input logic [15:0] ab, input string req);
    exp_t e;
    logic [15:0] p;
    e = '{ea: 16'h0, wb_en: 1'b0, wb_ptr: 2'd0, wb_val: 16'h0, illegal: 1'b0, req: req};
    p = (s == 2'd0) ? x : (s == 2'd1) ? y : z;
    if (m >= 3'd6 || (m >= 3'd2 && s == 2'd3) || (m == 3'd3 && s == 2'd0)) begin
      e.illegal = 1'b1;
    end else begin
      case (m)
        3'd0: e.ea = ab;
        3'd1: e.ea = 16'h0020 + {10'h0, io};
        3'd2: e.ea = p;
        3'd3: e.ea = p + {10'h0, d};
        3'd4: begin e.ea = p; e.wb_val = p + 16'd1; e.wb_en = 1'b1; e.wb_ptr = s; end
        default: begin e.ea = p - 16'd1; e.wb_val = p - 16'd1; e.wb_en = 1'b1; e.wb_ptr = s; end
      endcase
    end
    return e;
  endfunction

  task automatic send(input logic [2:0] m, input logic [1:0] s,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] z,
      input logic [5:0] d, input logic [5:0] io, input logic [15:0] ab, input string req);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; ptr_sel_i = s;
    ptr_x_i = x; ptr_y_i = y; ptr_z_i = z;
    disp_i = d; io_addr_i = io; abs_addr_i = ab;
    sb.push_back(model(m, s, x, y, z, d, io, ab, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      mode_i = 3'd4;
      ptr_sel_i = 2'd1;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", "unexpected valid_o", 16'h1, 16'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(ea_o == e.ea, e.req, "ea_o", ea_o, e.ea);
          check(wb_en_o == e.wb_en, e.req, "wb_en_o", {15'h0, wb_en_o}, {15'h0, e.wb_en});
          check(wb_val_o == e.wb_val, e.req, "wb_val_o", wb_val_o, e.wb_val);
          check(wb_ptr_o == e.wb_ptr, e.req, "wb_ptr_o", {14'h0, wb_ptr_o}, {14'h0, e.wb_ptr});
          check(illegal_o == e.illegal, e.req, "illegal_o", {15'h0, illegal_o}, {15'h0, e.illegal});
        end
      end else begin
        check(!wb_en_o && !illegal_o && wb_val_o == 16'h0, "R9", "idle outputs",
              {wb_en_o, illegal_o, wb_val_o[13:0]}, 16'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs under reset
    check({valid_o, wb_en_o, illegal_o} == 3'b0 && ea_o == 0 && wb_val_o == 0 && wb_ptr_o == 0,
          "R1", "outputs in reset", ea_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    check({valid_o, wb_en_o, illegal_o} == 3'b0 && ea_o == 0 && wb_val_o == 0 && wb_ptr_o == 0,
          "R1", "outputs after reset", ea_o, 16'h0);

    send(3'd0, 2'd3, 16'h1111, 16'h2222, 16'h3333, 6'd5, 6'd7, 16'h0100, "R2");
    send(3'd0, 2'd0, 16'h1111, 16'h2222, 16'h3333, 6'd5, 6'd7, 16'hFFFF, "R2");
    send(3'd1, 2'd3, 16'h1111, 16'h2222, 16'h3333, 6'd5, 6'd0, 16'h0100, "R3");
    send(3'd1, 2'd2, 16'h1111, 16'h2222, 16'h3333, 6'd5, 6'd63, 16'h0100, "R3");
    send(3'd2, 2'd0, 16'h1000, 16'h2000, 16'h3000, 6'd9, 6'd1, 16'h0, "R4");
    send(3'd2, 2'd1, 16'h1000, 16'h2000, 16'h3000, 6'd9, 6'd1, 16'h0, "R4");
    send(3'd2, 2'd2, 16'h1000, 16'h2000, 16'h3000, 6'd9, 6'd1, 16'h0, "R4");
    send(3'd3, 2'd1, 16'h1000, 16'h1000, 16'h3000, 6'd1, 6'd1, 16'h0, "R5");
    send(3'd3, 2'd2, 16'h1000, 16'h2000, 16'hFFF0, 6'd63, 6'd1, 16'h0, "R10");
    send(3'd3, 2'd0, 16'h1000, 16'h2000, 16'h3000, 6'd4, 6'd1, 16'h0, "R5");
    idle(2);
    send(3'd4, 2'd2, 16'h1000, 16'h2000, 16'h1234, 6'd0, 6'd0, 16'h0, "R6");
    send(3'd4, 2'd0, 16'hFFFF, 16'h2000, 16'h1234, 6'd0, 6'd0, 16'h0, "R10");
    send(3'd4, 2'd1, 16'hFFFF, 16'h00FF, 16'h1234, 6'd0, 6'd0, 16'h0, "R6");
    send(3'd5, 2'd1, 16'h1000, 16'h1000, 16'h3000, 6'd0, 6'd0, 16'h0, "R7");
    send(3'd5, 2'd0, 16'h0000, 16'h1000, 16'h3000, 6'd0, 6'd0, 16'h0, "R10");
    send(3'd5, 2'd2, 16'h0000, 16'h1000, 16'h8000, 6'd0, 6'd0, 16'h0, "R7");
    idle(1);
    send(3'd6, 2'd1, 16'h1000, 16'h2000, 16'h3000, 6'd3, 6'd3, 16'h4444, "R8");
    send(3'd7, 2'd2, 16'h1000, 16'h2000, 16'h3000, 6'd3, 6'd3, 16'h4444, "R8");
    send(3'd2, 2'd3, 16'h1000, 16'h2000, 16'h3000, 6'd3, 6'd3, 16'h4444, "R8");
    send(3'd4, 2'd3, 16'h1000, 16'h2000, 16'h3000, 6'd3, 6'd3, 16'h4444, "R8");
    send(3'd5, 2'd3, 16'h1000, 16'h2000, 16'h3000, 6'd3, 6'd3, 16'h4444, "R8");
    // R9: post-increment after an illegal request, then idle
    send(3'd4, 2'd1, 16'h1000, 16'h0042, 16'h3000, 6'd3, 6'd3, 16'h4444, "R9");
    idle(3);
    @(negedge clk);
    done = 1'b1;
    check(sb.size() == 0, "R9", "scoreboard drained", 16'(sb.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule